// File: doc/BRIEF.md
# Programmable Clock Divider Chain with Lock Handshake

This block produces a synthesized clock from a reference clock through three programmable stages: a pre-divider, a feedback multiplier and a post-divider. Each stage has one 32-bit control word. The word gives the stage's high-phase count and low-phase count, an edge flag for odd ratios, a pass-through flag and a stage-only flag. The analog loop is not modelled. In its place sits a digital rate generator that emits a tick stream at reference × feedback ratio / pre-divider ratio. The post-divider counts high and low phases over that tick stream to shape the output clock.

Software programs the block with a fixed sequence. It first writes the pre-divider and feedback words with the stage-only flag set, so those values wait in staging. It then writes the post-divider word with that flag clear, which applies all three staged words in the same cycle. A lock status bit drops for a fixed number of reference cycles after each apply and then rises again. Software polls that bit before it relies on the new frequency.

The block runs entirely in the reference clock domain. `out_en_o` is a one-cycle enable at every rising edge of the synthesized clock, and `out_clk_o` is its shaped level.

Top module: `ckdiv_top`

## Requirements
- R1: The control words sit at word index `addr_i[3:2]` = 0 (pre-divider), 1 (feedback) and 2 (post-divider). Each word is laid out as low count [5:0], high count [11:6], edge flag [12], pass-through [13], stage-only [14]. A read returns bits [14:0] of the last value written to that word, even if it is still only staged, and returns zero in bits [31:15].
- R2: Out of reset all three words read 0x2000 (pass-through only) and the lock word reads 1. `out_en_o` is 1 in every cycle, so the output runs at the reference rate.
- R3: A control write with bit 14 set changes only the staged value. The output pattern and the lock bit do not change.
- R4: A control write with bit 14 clear applies, in one cycle, its own value together with the staged values of the other two words.
- R5: The lock bit is bit 0 at word index 3. Writes to that word are ignored and bits [31:1] read zero. After an applying write, lock reads 0 in exactly LOCK_CYC consecutive cycles, starting the cycle after the write, and then returns to 1. A lock fall happens only after an applying write.
- R6: A stage's ratio is low count + high count, or 1 when pass-through is set. When the feedback ratio F does not exceed the pre-divider ratio I, any window of I×O cycles after lock contains exactly F pulses on `out_en_o`, where O is the post-divider ratio.
- R7: With the post-divider not bypassed, `out_clk_o` stays high for high-count ticks and then low for low-count ticks. An odd ratio N is encoded as low = (N>>1)+1, high = N>>1, edge = 1, and an even ratio as low = high = N/2, edge = 0.
- R8: `out_en_o` is 1 only in cycles where `out_clk_o` is 1. With the post-divider not bypassed, `out_en_o` marks exactly the cycles in which `out_clk_o` rises.
- R9: While lock is 0, both `out_en_o` and `out_clk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address; bits [3:2] select the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| lock_o | output | 1 | Lock status, the same value as bit 0 of word 3 |
| out_en_o | output | 1 | One-cycle pulse at each synthesized rising edge |
| out_clk_o | output | 1 | Shaped synthesized clock level |

## Verification
The lock-window checks assume that every applying write starts a complete LOCK_CYC-cycle count. The checker restarts its own run counter on each applying write, so writes that arrive while lock is low are still checked correctly. The rate and phase-length expectations assume that the feedback ratio never exceeds the pre-divider ratio. The sweep therefore visits only feedback ratios from 1 up to the pre-divider ratio, and it measures phase lengths only when the two ratios are equal, which makes every cycle a tick. Writes change inputs on falling edges and are one cycle long, so each write is a single clean strobe.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
    localparam int PH_W       = 6;
    localparam int RATIO_W    = PH_W + 1;
    localparam int NUM_STAGES = 3;
    localparam int CTL_W      = 15;
    localparam logic [1:0] IDX_LOCK = 2'd3;

    // Bit 14 down to bit 0 of a stage control word.
    typedef struct packed {
        logic            stage_only;
        logic            pass_thru;
        logic            odd_edge;
        logic [PH_W-1:0] hi_cnt;
        logic [PH_W-1:0] lo_cnt;
    } stage_ctl_t;

    localparam stage_ctl_t CTL_RESET = '{stage_only: 1'b0, pass_thru: 1'b1,
                                         odd_edge: 1'b0, hi_cnt: '0, lo_cnt: '0};

    // Effective ratio of one stage; a zero sum is treated as 1.
    function automatic logic [RATIO_W-1:0] stage_ratio(input stage_ctl_t c);
        logic [RATIO_W-1:0] sum;
        sum = RATIO_W'(c.lo_cnt) + RATIO_W'(c.hi_cnt);
        if (c.pass_thru || sum == '0) return RATIO_W'(1);
        return sum;
    endfunction

    // Phase length in ticks; a zero count is treated as 1.
    function automatic logic [PH_W-1:0] phase_len(input logic [PH_W-1:0] n);
        return (n == '0) ? PH_W'(1) : n;
    endfunction
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs
    import ckdiv_pkg::*;
#(
    parameter int LOCK_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  logic [3:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output stage_ctl_t  act_in_o,
    output stage_ctl_t  act_fb_o,
    output stage_ctl_t  act_out_o,
    output logic        locked_o,
    output logic        quiet_o
);
    localparam int LCK_W = $clog2(LOCK_CYC + 1);

    stage_ctl_t       staged_q [NUM_STAGES];
    stage_ctl_t       active_q [NUM_STAGES];
    logic [LCK_W-1:0] lock_cnt_q;
    logic [1:0]       idx;
    logic             ctl_wr;
    logic             commit;
    stage_ctl_t       wr_word;

    assign idx     = addr_i[3:2];
    assign ctl_wr  = wr_en_i && (idx != IDX_LOCK);
    assign wr_word = stage_ctl_t'(wdata_i[CTL_W-1:0]);
    assign commit  = ctl_wr && !wr_word.stage_only;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                staged_q[g] <= CTL_RESET;
                active_q[g] <= CTL_RESET;
            end else begin
                if (ctl_wr && idx == 2'(g))
                    staged_q[g] <= wr_word;
                if (commit)
                    active_q[g] <= (idx == 2'(g)) ? wr_word : staged_q[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lock_cnt_q <= '0;
        else if (commit)
            lock_cnt_q <= LCK_W'(LOCK_CYC);
        else if (lock_cnt_q != '0)
            lock_cnt_q <= lock_cnt_q - LCK_W'(1);
    end

    assign locked_o  = (lock_cnt_q == '0);
    assign quiet_o   = commit || !locked_o;
    assign act_in_o  = active_q[0];
    assign act_fb_o  = active_q[1];
    assign act_out_o = active_q[2];

    always_comb begin
        rdata_o = '0;
        case (idx)
            2'd0:    rdata_o[CTL_W-1:0] = staged_q[0];
            2'd1:    rdata_o[CTL_W-1:0] = staged_q[1];
            2'd2:    rdata_o[CTL_W-1:0] = staged_q[2];
            default: rdata_o[0]         = locked_o;
        endcase
    end
endmodule

// File: rtl/ckdiv_fbnco.sv
module ckdiv_fbnco
    import ckdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_i,
    input  stage_ctl_t in_ctl_i,
    input  stage_ctl_t fb_ctl_i,
    output logic       tick_o
);
    logic [RATIO_W-1:0] in_r;
    logic [RATIO_W-1:0] fb_r;
    logic [RATIO_W:0]   acc_q;
    logic [RATIO_W:0]   sum;
    logic               saturate;
    logic               wrap;

    assign in_r     = stage_ratio(in_ctl_i);
    assign fb_r     = stage_ratio(fb_ctl_i);
    assign sum      = acc_q + (RATIO_W+1)'(fb_r);
    assign saturate = (fb_r >= in_r);
    assign wrap     = (sum >= (RATIO_W+1)'(in_r));
    assign tick_o   = !hold_i && (saturate || wrap);

    always_ff @(posedge clk) begin
        if (rst || hold_i || saturate)
            acc_q <= '0;
        else if (wrap)
            acc_q <= sum - (RATIO_W+1)'(in_r);
        else
            acc_q <= sum;
    end
endmodule

// File: rtl/ckdiv_outstage.sv
module ckdiv_outstage
    import ckdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_i,
    input  logic       tick_i,
    input  stage_ctl_t ctl_i,
    output logic       en_o,
    output logic       clk_o
);
    logic            hi_q;
    logic            en_q;
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] hlen;
    logic [PH_W-1:0] llen;

    assign hlen = phase_len(ctl_i.hi_cnt);
    assign llen = phase_len(ctl_i.lo_cnt);

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            hi_q  <= 1'b0;
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else if (ctl_i.pass_thru) begin
            hi_q  <= tick_i;
            en_q  <= tick_i;
            cnt_q <= '0;
        end else begin
            en_q <= 1'b0;
            if (tick_i) begin
                if (hi_q) begin
                    if (cnt_q == hlen - PH_W'(1)) begin
                        hi_q  <= 1'b0;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + PH_W'(1);
                    end
                end else if (cnt_q == llen - PH_W'(1)) begin
                    hi_q  <= 1'b1;
                    en_q  <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + PH_W'(1);
                end
            end
        end
    end

    assign en_o  = en_q;
    assign clk_o = hi_q;
endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top
    import ckdiv_pkg::*;
#(
    parameter int LOCK_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  logic [3:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        lock_o,
    output logic        out_en_o,
    output logic        out_clk_o
);
    stage_ctl_t act_in;
    stage_ctl_t act_fb;
    stage_ctl_t act_out;
    logic       quiet;
    logic       tick;

    ckdiv_regs #(.LOCK_CYC(LOCK_CYC)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .act_in_o  (act_in),
        .act_fb_o  (act_fb),
        .act_out_o (act_out),
        .locked_o  (lock_o),
        .quiet_o   (quiet)
    );

    ckdiv_fbnco nco_i (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (quiet),
        .in_ctl_i (act_in),
        .fb_ctl_i (act_fb),
        .tick_o   (tick)
    );

    ckdiv_outstage post_i (
        .clk    (clk),
        .rst    (rst),
        .hold_i (quiet),
        .tick_i (tick),
        .ctl_i  (act_out),
        .en_o   (out_en_o),
        .clk_o  (out_clk_o)
    );
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk #(
    parameter int LOCK_CYC = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en_i,
    input logic [3:0]  addr_i,
    input logic [31:0] wdata_i,
    input logic        lock_o,
    input logic        out_en_o,
    input logic        out_clk_o
);
    localparam int RUN_W = $clog2(LOCK_CYC + 2) + 1;

    logic             ctl_wr;
    logic             commit;
    logic             staged_wr;
    logic [RUN_W-1:0] low_run;

    assign ctl_wr    = wr_en_i && (addr_i[3:2] != 2'd3);
    assign commit    = ctl_wr && !wdata_i[14];
    assign staged_wr = ctl_wr && wdata_i[14];

    always_ff @(posedge clk) begin
        if (rst || commit)
            low_run <= '0;
        else if (!lock_o && low_run < RUN_W'(LOCK_CYC + 1))
            low_run <= low_run + RUN_W'(1);
    end

    // R5
    lock_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_o) |-> $past(commit));

    // R5
    lock_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> low_run == RUN_W'(LOCK_CYC));

    // R5
    lock_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_o |-> low_run < RUN_W'(LOCK_CYC));

    // R3
    staged_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_o && staged_wr) |=> lock_o);

    // R9
    quiet_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_o |-> (!out_en_o && !out_clk_o));

    // R8
    en_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        out_en_o |-> out_clk_o);
endmodule

bind ckdiv_top ckdiv_chk #(.LOCK_CYC(LOCK_CYC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .lock_o    (lock_o),
    .out_en_o  (out_en_o),
    .out_clk_o (out_clk_o)
);

// File: tb/ckdiv_top_tb_top.sv
module ckdiv_top_tb_top;
    localparam int LOCK_CYC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        lock_o;
    logic        out_en_o;
    logic        out_clk_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ckdiv_top #(.LOCK_CYC(LOCK_CYC)) dut_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .lock_o(lock_o),
        .out_en_o(out_en_o), .out_clk_o(out_clk_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int n, input bit apply);
        logic [31:0] w;
        w = '0;
        if (n == 1) begin
            w[13] = 1'b1;
        end else begin
            w[5:0]  = 6'((n % 2 == 1) ? (n >> 1) + 1 : (n >> 1));
            w[11:6] = 6'(n >> 1);
            w[12]   = (n % 2 == 1);
        end
        w[14] = !apply;
        return w;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    // Sample out_en_o over n cycles; returns pulse count and cycles not at 1.
    task automatic count_en(input int n, output int pulses, output int not_one);
        pulses = 0; not_one = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_en_o) pulses++; else not_one++;
        end
    endtask

    // Called right after an applying write: measures the unlocked run.
    task automatic wait_lock(input string tag);
        int n;
        int loud;
        n = 0; loud = 0;
        while (!lock_o && n < 200) begin
            if (out_en_o || out_clk_o) loud++;
            n++;
            @(negedge clk);
        end
        check(n == LOCK_CYC, tag, n, LOCK_CYC);
        check(loud == 0, "R9 outputs quiet while unlocked", loud, 0);
    endtask

    task automatic run_case(input int ni, input int nf, input int no);
        logic [31:0] d;
        int pulses;
        int bad;
        int hi_len;
        int lo_len;
        bit prev;
        wr(4'h0, enc(ni, 1'b0));
        wr(4'h4, enc(nf, 1'b0));
        rd(4'hC, d);
        check(d == 32'd1, "R3 lock unchanged by staged write", d, 1);
        wr(4'h8, enc(no, 1'b1));
        wait_lock("R5 lock low window");
        rd(4'h8, d);
        check(d == (enc(no, 1'b1) & 32'h7FFF), "R1 readback", d, enc(no, 1'b1) & 32'h7FFF);
        repeat (ni * no) @(negedge clk);
        pulses = 0; bad = 0; prev = out_clk_o;
        for (int i = 0; i < 2 * ni * no; i++) begin
            @(negedge clk);
            if (out_en_o) pulses++;
            if (out_en_o && !out_clk_o) bad++;
            if (no > 1 && (out_en_o != (out_clk_o && !prev))) bad++;
            prev = out_clk_o;
        end
        check(pulses == 2 * nf, "R6 pulse count per window", pulses, 2 * nf);
        check(bad == 0, "R8 enable aligned with rising level", bad, 0);
        if (nf == ni && no > 1) begin
            while (out_clk_o) @(negedge clk);
            while (!out_clk_o) @(negedge clk);
            hi_len = 0;
            while (out_clk_o) begin hi_len++; @(negedge clk); end
            lo_len = 0;
            while (!out_clk_o) begin lo_len++; @(negedge clk); end
            check(hi_len == (no >> 1), "R7 high phase length", hi_len, no >> 1);
            check(lo_len == no - (no >> 1), "R7 low phase length", lo_len, no - (no >> 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int pulses;
        int not_one;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        rd(4'h0, d); check(d == 32'h2000, "R2 pre-divider reset word", d, 32'h2000);
        rd(4'h4, d); check(d == 32'h2000, "R2 feedback reset word", d, 32'h2000);
        rd(4'h8, d); check(d == 32'h2000, "R2 post-divider reset word", d, 32'h2000);
        rd(4'hC, d); check(d == 32'd1, "R2 lock after reset", d, 1);
        count_en(20, pulses, not_one);
        check(not_one == 0, "R2 output at reference rate", not_one, 0);

        // R1 and R3: staged write, reserved bits zero, no effect on output
        wr(4'h0, 32'hFFFF_5ABC);
        rd(4'h0, d); check(d == 32'h0000_5ABC, "R1 staged readback, reserved zero", d, 32'h5ABC);
        rd(4'hC, d); check(d == 32'd1, "R3 lock kept", d, 1);
        count_en(20, pulses, not_one);
        check(not_one == 0, "R3 output unchanged after staging", not_one, 0);
        wr(4'h0, 32'h0000_6000);

        // R5: lock word ignores writes
        wr(4'hC, 32'h0000_0000);
        rd(4'hC, d); check(d == 32'd1, "R5 lock word write ignored", d, 1);
        check(lock_o == 1'b1, "R5 lock pin after lock-word write", lock_o, 1);

        // R4: applying write to the pre-divider commits staged post/feedback too
        wr(4'h8, enc(2, 1'b0));
        wr(4'h4, enc(1, 1'b0));
        wr(4'h0, enc(2, 1'b1));
        wait_lock("R5 lock low window");
        repeat (4) @(negedge clk);
        count_en(8, pulses, not_one);
        check(pulses == 2, "R4 all staged words applied together", pulses, 2);

        // R6 R7 R8 R9 sweep
        for (int ni = 1; ni <= 3; ni++)
            for (int nf = 1; nf <= ni; nf++)
                for (int no = 1; no <= 5; no++)
                    run_case(ni, nf, no);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule